// File: doc/BRIEF.md
# Parallel Converter Port Controller

This block is the digital side of a 12-bit sampling converter with a parallel host port. A falling edge on the active-low start strobe begins a conversion of fixed length, counted in system clock cycles. A stand-in sample input supplies the converted value. The block signals a conversion in progress on an active-low busy line. It then places the result in an output register, which the host reads over a shared 12-bit bus using active-low chip select and read.

The same bus carries an offset word in the other direction. When a high pulse on the write strobe ends while chip select is low, the bus contents are captured into an offset register. A mode input selects when a finished result reaches the output register. In immediate mode it is loaded as the conversion ends. In deferred mode it is held back until the next accepted start edge. Standby and nap inputs put the block in a low-power state that refuses new conversions and abandons a conversion in flight.

Every strobe and level input is brought into the system clock domain through a synchroniser before use. The three-state bus is split into an input word, an output word and a drive enable, for a pad ring outside the block.

Top module: `padc_port`

## Requirements
- R1: busy_o is high while idle. After an accepted falling edge of conv_n_i it goes low and stays low for exactly CONV_CYCLES clock cycles (default 20).
- R2: With mode2_i low (immediate mode), busy_o returns high in the same cycle that the output register takes the value sample_i held in the last cycle of the conversion. A following read returns that value.
- R3: With mode2_i high (deferred mode), busy_o returns high while the output register keeps its previous value. The finished result is moved into the output register at the next accepted falling edge of conv_n_i.
- R4: data_oe_o is high, and data_o equals the output register, only while cs_n_i and rd_n_i are both low and wr_i is low. Otherwise data_oe_o is low.
- R5: With cs_n_i held low permanently, reads through rd_n_i and offset writes through wr_i both work.
- R6: data_i is captured into offset_o at the falling edge of a high pulse on wr_i when cs_n_i is low. A write pulse with cs_n_i high leaves offset_o unchanged.
- R7: While stby_i or nap_i is high, conv_n_i edges are ignored, busy_o stays high and the output register is unchanged.
- R8: If stby_i or nap_i rises during a conversion, the conversion is abandoned: busy_o returns high and the output register is not loaded.
- R9: Reset (rst_ni low) clears the output register and offset_o to zero, sets busy_o high and data_oe_o low.
- R10: When rd_n_i and wr_i are asserted together, with cs_n_i low, the write takes priority and data_oe_o stays low.
- R11: A falling edge of conv_n_i during a conversion neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_n_i | input | 1 | Conversion start strobe; the falling edge starts a conversion |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_i | input | 1 | Offset write strobe; the falling edge of a high pulse writes |
| stby_i | input | 1 | Standby request, active high |
| nap_i | input | 1 | Nap request, active high |
| mode2_i | input | 1 | 0: immediate result latch, 1: deferred result latch |
| sample_i | input | 12 | Stand-in converter result |
| data_i | input | 12 | Bus word from the pad, for offset writes |
| data_o | output | 12 | Bus word to the pad during reads |
| data_oe_o | output | 1 | Pad drive enable; low means high impedance |
| busy_o | output | 1 | Low while a conversion is running |
| offset_o | output | 12 | Offset register contents |

## Verification
The hardest state to reach is the deferred-mode pipeline: a finished result sits in the hidden pending register, and the output register still shows the older value. The bench runs several back-to-back deferred conversions with distinct sample values. It reads after each one, so every read shows the result from one conversion earlier. It then switches back to immediate mode, which shows that the pending value is flushed at the next start and then overwritten. Abandoning a conversion needs nap to be raised after busy has fallen but before the counter ends. The bench waits for the busy edge at the port and then raises nap a few cycles later.

// File: rtl/padc_pkg.sv
package padc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_e;

  // bit positions in the synchronised control vector
  localparam int unsigned SIG_CONV  = 0;
  localparam int unsigned SIG_CS    = 1;
  localparam int unsigned SIG_RD    = 2;
  localparam int unsigned SIG_WR    = 3;
  localparam int unsigned SIG_STBY  = 4;
  localparam int unsigned SIG_NAP   = 5;
  localparam int unsigned SIG_MODE2 = 6;
  localparam int unsigned SIG_NUM   = 7;

  // idle levels of the control inputs
  localparam logic [SIG_NUM-1:0] SIG_IDLE = 7'b000_0111;
endpackage

// File: rtl/padc_sync.sv
module padc_sync #(
  parameter int unsigned        W       = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= RST_VAL;
    else         pipe_q[0] <= in_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST_VAL;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= pipe_q[STAGES-1];
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~prev_q;
  assign fall_o = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/padc_conv.sv
module padc_conv
  import padc_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_fall_i,
  input  logic              lowpwr_i,
  input  logic              mode2_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned CNT_W    = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  conv_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] pend_q;
  logic              pend_vld_q;
  logic              accept;

  assign accept = start_fall_i && !lowpwr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      result_q   <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_CONV;
            cnt_q   <= CNT_LOAD;
            // deferred result moves out on the next accepted start
            if (pend_vld_q) begin
              result_q   <= pend_q;
              pend_vld_q <= 1'b0;
            end
          end
        end
        ST_CONV: begin
          if (lowpwr_i) begin
            state_q <= ST_IDLE;
          end else if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            if (mode2_i) begin
              pend_q     <= sample_i;
              pend_vld_q <= 1'b1;
            end else begin
              result_q <= sample_i;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_IDLE);
  assign result_o = result_q;

  AST_BUSY_FALL_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(start_fall_i && !lowpwr_i)); // R1

  AST_IMMEDIATE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !$past(mode2_i) && !$past(lowpwr_i)) |-> (result_o == $past(sample_i))); // R2

  AST_DEFERRED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(mode2_i)) |-> $stable(result_o)); // R3

  AST_RESULT_CHANGE_POINTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> ($past(start_fall_i) || $rose(busy_o))); // R3

  AST_LOWPWR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_i |=> busy_o); // R7

  AST_ABANDON_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(lowpwr_i)) |-> $stable(result_o)); // R8
endmodule

// File: rtl/padc_bus.sv
module padc_bus #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_i,
  input  logic              wr_fall_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] offset_o
);
  logic [DATA_W-1:0] offset_q;
  logic              drive;

  // write wins over read
  assign drive = !cs_n_i && !rd_n_i && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    offset_q <= '0;
    else if (wr_fall_i && !cs_n_i)  offset_q <= data_i;
  end

  assign data_oe_o = drive;
  assign data_o    = drive ? result_i : '0;
  assign offset_o  = offset_q;

  AST_WRITE_BLOCKS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !data_oe_o); // R10

  AST_OFFSET_ON_WR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(offset_o) |-> $past(wr_fall_i && !cs_n_i)); // R6

  AST_DRIVE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (data_o == result_i)); // R4
endmodule

// File: rtl/padc_port.sv
module padc_port
  import padc_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_n_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_i,
  input  logic              stby_i,
  input  logic              nap_i,
  input  logic              mode2_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] offset_o
);
  logic [SIG_NUM-1:0] raw;
  logic [SIG_NUM-1:0] lvl;
  logic [SIG_NUM-1:0] rise;
  logic [SIG_NUM-1:0] fall;
  logic [DATA_W-1:0]  result;
  logic               lowpwr;

  always_comb begin
    raw            = '0;
    raw[SIG_CONV]  = conv_n_i;
    raw[SIG_CS]    = cs_n_i;
    raw[SIG_RD]    = rd_n_i;
    raw[SIG_WR]    = wr_i;
    raw[SIG_STBY]  = stby_i;
    raw[SIG_NAP]   = nap_i;
    raw[SIG_MODE2] = mode2_i;
  end

  padc_sync #(
    .W      (SIG_NUM),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SIG_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (raw),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign lowpwr = lvl[SIG_STBY] || lvl[SIG_NAP];

  padc_conv #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_conv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_fall_i (fall[SIG_CONV]),
    .lowpwr_i     (lowpwr),
    .mode2_i      (lvl[SIG_MODE2]),
    .sample_i     (sample_i),
    .busy_o       (busy_o),
    .result_o     (result)
  );

  padc_bus #(
    .DATA_W(DATA_W)
  ) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (lvl[SIG_CS]),
    .rd_n_i    (lvl[SIG_RD]),
    .wr_i      (lvl[SIG_WR]),
    .wr_fall_i (fall[SIG_WR]),
    .data_i    (data_i),
    .result_i  (result),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .offset_o  (offset_o)
  );

  logic unused_rise;
  assign unused_rise = ^rise;
endmodule

// File: tb/padc_port_bench.sv
module padc_port_bench;
  localparam int unsigned DW = 12;
  localparam int unsigned CC = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr = 1'b0;
  logic          stby = 1'b0, nap = 1'b0, mode2 = 1'b0;
  logic [DW-1:0] sample = '0, din = '0;
  logic [DW-1:0] dout, offset;
  logic          oe, busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic [DW-1:0] val;
    string         req;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  padc_port #(.DATA_W(DW), .CONV_CYCLES(CC)) u_padc_port (
    .clk_i(clk), .rst_ni(rst_n), .conv_n_i(conv_n), .cs_n_i(cs_n),
    .rd_n_i(rd_n), .wr_i(wr), .stby_i(stby), .nap_i(nap), .mode2_i(mode2),
    .sample_i(sample), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .busy_o(busy), .offset_o(offset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: each new bus drive pops one expected read
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4 unexpected drive", int'(dout), 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(dout == it.val, it.req, int'(dout), int'(it.val));
      end
    end
    oe_prev = oe;
  end

  task automatic do_read(input logic [DW-1:0] v, input string req, input bit keep_cs);
    exp_q.push_back('{val: v, req: req});
    @(negedge clk);
    if (!keep_cs) cs_n = 1'b0;
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    if (!keep_cs) cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [DW-1:0] v, input bit cs_high, input bit keep_cs);
    @(negedge clk);
    din = v;
    if (!keep_cs) cs_n = cs_high;
    wr = 1'b1;
    repeat (4) @(negedge clk);
    wr = 1'b0;
    repeat (4) @(negedge clk);
    if (!keep_cs) cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_conv(input logic [DW-1:0] smp, input bit extra, output int low_cnt);
    int w;
    sample = smp;
    @(negedge clk);
    conv_n = 1'b0;
    repeat (2) @(negedge clk);
    conv_n = 1'b1;
    w = 0;
    while (busy && w < 10) begin
      @(negedge clk);
      w++;
    end
    low_cnt = 0;
    while (!busy && low_cnt < 1000) begin
      low_cnt++;
      if (extra && low_cnt == 5) conv_n = 1'b0;
      if (extra && low_cnt == 8) conv_n = 1'b1;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet_start(input string req);
    bit stayed;
    stayed = 1;
    @(negedge clk);
    conv_n = 1'b0;
    repeat (2) @(negedge clk);
    conv_n = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (!busy) stayed = 0;
    end
    chk(stayed, req, int'(stayed), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy == 1'b1, "R9 busy", int'(busy), 1);
    chk(oe == 1'b0, "R9 oe", int'(oe), 0);
    chk(offset == '0, "R9 offset", int'(offset), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(12'h000, "R9 result cleared", 0);

    // R1, R2 immediate mode
    run_conv(12'hA5C, 0, cnt);
    chk(cnt == CC, "R1 busy low length", cnt, CC);
    do_read(12'hA5C, "R2 immediate latch", 0);

    // R11 extra start edge mid-conversion
    run_conv(12'h3C1, 1, cnt);
    chk(cnt == CC, "R11 no restart", cnt, CC);
    do_read(12'h3C1, "R11 result", 0);

    // R7 standby and nap
    sample = 12'hBBB;
    stby = 1'b1;
    repeat (4) @(negedge clk);
    quiet_start("R7 stby busy high");
    stby = 1'b0;
    repeat (4) @(negedge clk);
    do_read(12'h3C1, "R7 stby result kept", 0);
    nap = 1'b1;
    repeat (4) @(negedge clk);
    quiet_start("R7 nap busy high");
    nap = 1'b0;
    repeat (4) @(negedge clk);
    do_read(12'h3C1, "R7 nap result kept", 0);

    // R8 abandon on nap mid-conversion
    sample = 12'h777;
    @(negedge clk);
    conv_n = 1'b0;
    repeat (2) @(negedge clk);
    conv_n = 1'b1;
    begin
      int w;
      w = 0;
      while (busy && w < 10) begin @(negedge clk); w++; end
    end
    repeat (3) @(negedge clk);
    nap = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R8 busy after abandon", int'(busy), 1);
    nap = 1'b0;
    repeat (4) @(negedge clk);
    do_read(12'h3C1, "R8 no load", 0);

    // R3 deferred mode
    mode2 = 1'b1;
    repeat (4) @(negedge clk);
    run_conv(12'h111, 0, cnt);
    chk(cnt == CC, "R3 busy length", cnt, CC);
    do_read(12'h3C1, "R3 old value held", 0);
    run_conv(12'h222, 0, cnt);
    do_read(12'h111, "R3 latched at next start", 0);
    run_conv(12'h333, 0, cnt);
    do_read(12'h222, "R3 second deferral", 0);
    mode2 = 1'b0;
    repeat (4) @(negedge clk);
    run_conv(12'h444, 0, cnt);
    do_read(12'h444, "R2 back to immediate", 0);

    // R6 offset writes
    do_write(12'h5A5, 0, 0);
    chk(offset == 12'h5A5, "R6 write", int'(offset), 'h5A5);
    do_write(12'hF0F, 1, 0);
    chk(offset == 12'h5A5, "R6 cs high ignored", int'(offset), 'h5A5);

    // R4 read without chip select
    @(negedge clk);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(oe == 1'b0, "R4 no drive cs high", int'(oe), 0);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 chip select tied low
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    do_write(12'h0F0, 0, 1);
    chk(offset == 12'h0F0, "R5 write cs tied", int'(offset), 'h0F0);
    do_read(12'h444, "R5 read cs tied", 1);

    // R10 read and write together
    din = 12'h9A9;
    rd_n = 1'b0;
    wr = 1'b1;
    repeat (4) @(negedge clk);
    chk(oe == 1'b0, "R10 write priority", int'(oe), 0);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(offset == 12'h9A9, "R10 write applied", int'(offset), 'h9A9);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(exp_q.size() == 0, "R4 reads outstanding", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule